// File: doc/BRIEF.md
# Scalar Fence Request Issuer

This block sits between the scalar issue logic of a compute unit and the port of the scalar instruction/constant cache. It takes one scalar memory-fence command at a time. Each command carries a wavefront ID, an instruction sequence number, a kernel-scope flag, per-instruction attribute flags and a system flag. The block waits for a delay that software sets. It then issues a cache-synchronisation request with a zero address and a fixed sync command code.

A request marked as a system request goes out as a one-cycle pulse on a separate hub port. Every other request goes to the cache port, which uses valid/ready. If the cache port refuses a request, the block parks it in a small in-order retry FIFO. The FIFO replays the entries later, and any newer requests queue behind them. The `busy` output is high while a fence is in its delay phase or waiting for room. While `busy` is high the block takes no new command.

Top module: `sfence_issuer`

## Requirements
- R1: Every request on either port carries address zero and the sync command code 4'hA.
- R2: When the kernel flag is set, the attribute field has bit 0 (invalidate L1) and bit 1 (kernel scope) set and every other bit clear.
- R3: When the kernel flag is clear, the attribute field equals the per-instruction flags sampled at injection.
- R4: Each request carries the wavefront ID and sequence number of the fence that produced it.
- R5: With delay value L sampled at the injection edge, a request with an empty retry FIFO first appears on its port in the cycle after the L-th rising edge that follows the injection edge.
- R6: `busy` is high from the edge after injection until the request leaves the delay stage. An injection offered while `busy` is high is ignored and never produces a request.
- R7: A system request appears on the hub port for exactly one cycle, and the cache port shows no valid for it.
- R8: A cache request refused in its first cycle (valid high, ready low) enters a retry FIFO of depth 4. Cache-routed requests are accepted in the order they were injected.
- R9: An entry from the non-empty retry FIFO is shown on the cache port only in a cycle that follows a cycle with `cq_ready` high.
- R10: While the retry FIFO holds entries, a newly due cache request goes into the FIFO and does not go straight to the port. If the FIFO is full, the request stays in the delay stage and `busy` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lat_cfg | input | LAT_W | Delay in cycles, sampled at injection |
| inj_valid | input | 1 | Fence command offered |
| inj_wave | input | WAVE_W | Wavefront ID |
| inj_seq | input | SEQ_W | Instruction sequence number |
| inj_kernel | input | 1 | Kernel-scope fence |
| inj_flags | input | ATTR_W | Per-instruction attribute flags |
| inj_system | input | 1 | Route to the hub port |
| busy | output | 1 | Delay stage occupied; injection blocked |
| cq_valid | output | 1 | Cache request valid |
| cq_ready | input | 1 | Cache port accepts |
| cq_addr | output | ADDR_W | Cache request address |
| cq_cmd | output | 4 | Cache request command |
| cq_attr | output | ATTR_W | Cache request attributes |
| cq_seq | output | SEQ_W | Cache request sequence number |
| cq_wave | output | WAVE_W | Cache request wavefront ID |
| hq_valid | output | 1 | Hub request pulse |
| hq_addr | output | ADDR_W | Hub request address |
| hq_cmd | output | 4 | Hub request command |
| hq_attr | output | ATTR_W | Hub request attributes |
| hq_seq | output | SEQ_W | Hub request sequence number |
| hq_wave | output | WAVE_W | Hub request wavefront ID |

## Verification
The bench uses the default parameters: a 4-entry retry FIFO, a 4-bit delay field, 8-bit attributes and 16-bit sequence numbers. The shallow FIFO lets a burst of five refused requests fill it and stall the fifth in the delay stage. The attribute width leaves six bits above the two kernel bits, so the test can show that random flags are replaced. Delays from 0 to 6 cover both the same-cycle issue and the multi-cycle count.

// File: rtl/sfence_pkg.sv
`timescale 1ns/1ps
package sfence_pkg;
   localparam int          CMD_W       = 4;
   localparam logic [3:0]  CMD_MEMSYNC = 4'hA;
   localparam int          ATTR_INV    = 0;
   localparam int          ATTR_KERN   = 1;
endpackage

// File: rtl/sfence_delay.sv
`timescale 1ns/1ps
module sfence_delay #(
   parameter int LAT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LAT_W-1:0] lat,
   input  logic             release_i,
   output logic             pending,
   output logic             due
);
   logic [LAT_W-1:0] cnt;

   if (LAT_W < 1) begin : g_bad_lat
      $error("sfence_delay: LAT_W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending <= 1'b0;
         cnt     <= '0;
      end else if (load) begin
         pending <= 1'b1;
         cnt     <= lat;
      end else if (release_i) begin
         pending <= 1'b0;
      end else if (pending && cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign due = pending && (cnt == '0);

   // R5: count moves down one per cycle while waiting
   a_r5_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && cnt != '0 && !load) |=> (cnt == $past(cnt) - 1'b1));
   // R5: nothing leaves before the count has run out
   a_r5_no_early: assert property (@(posedge clk) disable iff (!rst_n)
      release_i |-> due);
   // R6: no second fence enters while one is waiting
   a_r6_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
      pending |-> !load);
endmodule

// File: rtl/sfence_fifo.sv
`timescale 1ns/1ps
module sfence_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int PW = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("sfence_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [PW:0]   count;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) begin
            mem[wr_ptr] <= din;
            wr_ptr      <= wr_ptr + 1'b1;
         end
         if (pop) rd_ptr <= rd_ptr + 1'b1;
         if (push && !pop)      count <= count + 1'b1;
         else if (pop && !push) count <= count - 1'b1;
      end
   end

   assign dout  = mem[rd_ptr];
   assign empty = (count == '0);
   assign full  = (count == (PW+1)'(DEPTH));

   // R8: the retry store never overflows or underflows
   a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/sfence_issuer.sv
`timescale 1ns/1ps
module sfence_issuer
   import sfence_pkg::*;
#(
   parameter int WAVE_W = 6,
   parameter int SEQ_W  = 16,
   parameter int ATTR_W = 8,
   parameter int ADDR_W = 48,
   parameter int LAT_W  = 4,
   parameter int QDEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LAT_W-1:0]  lat_cfg,
   input  logic              inj_valid,
   input  logic [WAVE_W-1:0] inj_wave,
   input  logic [SEQ_W-1:0]  inj_seq,
   input  logic              inj_kernel,
   input  logic [ATTR_W-1:0] inj_flags,
   input  logic              inj_system,
   output logic              busy,
   output logic              cq_valid,
   input  logic              cq_ready,
   output logic [ADDR_W-1:0] cq_addr,
   output logic [CMD_W-1:0]  cq_cmd,
   output logic [ATTR_W-1:0] cq_attr,
   output logic [SEQ_W-1:0]  cq_seq,
   output logic [WAVE_W-1:0] cq_wave,
   output logic              hq_valid,
   output logic [ADDR_W-1:0] hq_addr,
   output logic [CMD_W-1:0]  hq_cmd,
   output logic [ATTR_W-1:0] hq_attr,
   output logic [SEQ_W-1:0]  hq_seq,
   output logic [WAVE_W-1:0] hq_wave
);
   localparam int EW = WAVE_W + SEQ_W + ATTR_W;

   if (ATTR_W < 2) begin : g_bad_attr
      $error("sfence_issuer: ATTR_W must hold the two kernel bits");
   end

   // kernel-scope attribute word
   logic [ATTR_W-1:0] kern_attr;
   assign kern_attr[ATTR_INV]  = 1'b1;
   assign kern_attr[ATTR_KERN] = 1'b1;
   if (ATTR_W > 2) begin : g_pad
      assign kern_attr[ATTR_W-1:2] = '0;
   end

   logic              go, due, pend, release_w;
   logic [WAVE_W-1:0] p_wave;
   logic [SEQ_W-1:0]  p_seq;
   logic [ATTR_W-1:0] p_attr;
   logic              p_sys, p_kern;

   assign go = inj_valid && !pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         p_wave <= '0;
         p_seq  <= '0;
         p_attr <= '0;
         p_sys  <= 1'b0;
         p_kern <= 1'b0;
      end else if (go) begin
         p_wave <= inj_wave;
         p_seq  <= inj_seq;
         p_attr <= inj_kernel ? kern_attr : inj_flags;
         p_sys  <= inj_system;
         p_kern <= inj_kernel;
      end
   end

   sfence_delay #(.LAT_W(LAT_W)) u_delay (
      .clk(clk), .rst_n(rst_n), .load(go), .lat(lat_cfg),
      .release_i(release_w), .pending(pend), .due(due)
   );

   // retry path
   logic          q_empty, q_full, q_push, q_pop, rdy_d, replay, new_cache;
   logic [EW-1:0] q_head;

   always_ff @(posedge clk) begin
      if (!rst_n) rdy_d <= 1'b0;
      else        rdy_d <= cq_ready;
   end

   assign replay    = !q_empty && rdy_d;
   assign new_cache = due && !p_sys && q_empty;
   assign q_push    = due && !p_sys && (q_empty ? !cq_ready : !q_full);
   assign q_pop     = replay && cq_ready;
   assign hq_valid  = due && p_sys;
   assign release_w = hq_valid || (new_cache && cq_ready) || q_push;

   sfence_fifo #(.W(EW), .DEPTH(QDEPTH)) u_retry (
      .clk(clk), .rst_n(rst_n), .push(q_push), .din({p_wave, p_seq, p_attr}),
      .pop(q_pop), .dout(q_head), .empty(q_empty), .full(q_full)
   );

   assign busy     = pend;
   assign cq_valid = replay || new_cache;
   assign cq_addr  = '0;
   assign cq_cmd   = CMD_MEMSYNC;
   assign {cq_wave, cq_seq, cq_attr} = replay ? q_head : {p_wave, p_seq, p_attr};

   assign hq_addr  = '0;
   assign hq_cmd   = CMD_MEMSYNC;
   assign hq_wave  = p_wave;
   assign hq_seq   = p_seq;
   assign hq_attr  = p_attr;

   // R7: a hub request lasts exactly one cycle
   a_r7_hub_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      hq_valid |=> !hq_valid);
   // R9: queued entries only follow a ready cycle
   a_r9_replay_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (cq_valid && !q_empty) |-> $past(cq_ready));
   // R10: a full queue keeps the fence in the delay stage
   a_r10_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (due && !p_sys && q_full && !q_pop) |=> busy);
   // R6: busy only rises after an offered command
   a_r6_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(inj_valid));
   // R2: kernel fences carry both invalidate and kernel bits
   a_r2_kernel_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (hq_valid && p_kern) |-> (hq_attr[ATTR_INV] && hq_attr[ATTR_KERN]));
endmodule

// File: tb/sim_sfence_issuer.sv
`timescale 1ns/1ps
module sim_sfence_issuer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  lat_cfg = '0;
   logic        inj_valid = 1'b0;
   logic [5:0]  inj_wave = '0;
   logic [15:0] inj_seq = '0;
   logic        inj_kernel = 1'b0;
   logic [7:0]  inj_flags = '0;
   logic        inj_system = 1'b0;
   logic        cq_ready = 1'b0;
   logic        busy, cq_valid, hq_valid;
   logic [47:0] cq_addr, hq_addr;
   logic [3:0]  cq_cmd, hq_cmd;
   logic [7:0]  cq_attr, hq_attr;
   logic [15:0] cq_seq, hq_seq;
   logic [5:0]  cq_wave, hq_wave;

   always #4 clk = ~clk;

   sfence_issuer u0 (
      .clk(clk), .rst_n(rst_n), .lat_cfg(lat_cfg), .inj_valid(inj_valid),
      .inj_wave(inj_wave), .inj_seq(inj_seq), .inj_kernel(inj_kernel),
      .inj_flags(inj_flags), .inj_system(inj_system), .busy(busy),
      .cq_valid(cq_valid), .cq_ready(cq_ready), .cq_addr(cq_addr),
      .cq_cmd(cq_cmd), .cq_attr(cq_attr), .cq_seq(cq_seq), .cq_wave(cq_wave),
      .hq_valid(hq_valid), .hq_addr(hq_addr), .hq_cmd(hq_cmd),
      .hq_attr(hq_attr), .hq_seq(hq_seq), .hq_wave(hq_wave)
   );

   int total = 0;
   int bad = 0;
   int acc_c = 0;
   logic [29:0] exp_c[$];
   logic [29:0] exp_h[$];

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_attr(input logic kern, input logic [7:0] fl);
      return kern ? 8'h03 : fl;   // R2 / R3
   endfunction

   task automatic observe();
      logic [29:0] e;
      if (hq_valid) begin
         chk(hq_addr == 0 && hq_cmd == 4'hA, "R1 hub", {hq_cmd, hq_addr}, 64'hA << 48);
         if (exp_h.size() == 0) chk(0, "R7 unexpected hub", 64'(hq_seq), 0);
         else begin
            e = exp_h.pop_front();
            chk({hq_wave, hq_seq, hq_attr} == e, "R4 hub payload",
                64'({hq_wave, hq_seq, hq_attr}), 64'(e));
         end
      end
      if (cq_valid && cq_ready) begin
         acc_c++;
         chk(cq_addr == 0 && cq_cmd == 4'hA, "R1 cache", {cq_cmd, cq_addr}, 64'hA << 48);
         if (exp_c.size() == 0) chk(0, "R6 unexpected cache", 64'(cq_seq), 0);
         else begin
            e = exp_c.pop_front();
            chk({cq_wave, cq_seq, cq_attr} == e, "R8 order/R4 payload",
                64'({cq_wave, cq_seq, cq_attr}), 64'(e));
         end
      end
   endtask

   task automatic cycle(input bit iv, input logic [5:0] w, input logic [15:0] s,
                        input bit k, input logic [7:0] f, input bit sy,
                        input logic [3:0] l, input bit rdy);
      @(negedge clk);
      inj_valid = iv; inj_wave = w; inj_seq = s; inj_kernel = k;
      inj_flags = f; inj_system = sy; lat_cfg = l; cq_ready = rdy;
      if (iv && !busy) begin
         if (sy) exp_h.push_back({w, s, exp_attr(k, f)});
         else    exp_c.push_back({w, s, exp_attr(k, f)});
      end
      #1;
      observe();
   endtask

   task automatic idle(input bit rdy);
      cycle(0, 6'h0, 16'h0, 0, 8'h0, 0, 4'h0, rdy);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int n;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      #1;
      chk(!busy && !cq_valid && !hq_valid, "R6 reset state",
          {busy, cq_valid, hq_valid}, 0);
      rst_n = 1'b1;

      // R5 latency 3, R2 kernel attribute, R6 ignored injection
      cycle(1, 6'h11, 16'h1001, 1, 8'hFF, 0, 4'd3, 1);
      idle(1);
      chk(busy && !cq_valid, "R6 busy after inject", {busy, cq_valid}, 2'b10);
      cycle(1, 6'h22, 16'hDEAD, 0, 8'h55, 0, 4'd0, 1);
      chk(!cq_valid, "R5 not early", cq_valid, 0);
      idle(1);
      chk(!cq_valid, "R5 not early 2", cq_valid, 0);
      idle(1);
      chk(cq_valid && cq_attr == 8'h03, "R5 issue at L / R2 attr",
          {cq_valid, cq_attr}, 9'h103);
      idle(1);
      chk(!busy, "R6 busy cleared", busy, 0);
      repeat (4) idle(1);
      chk(exp_c.size() == 0 && !cq_valid, "R6 ignored injection absent",
          exp_c.size(), 0);

      // R5 zero latency, R3 flags pass-through
      cycle(1, 6'h05, 16'h0050, 0, 8'hA4, 0, 4'd0, 1);
      idle(1);
      chk(cq_valid && cq_attr == 8'hA4, "R5 zero delay / R3 flags",
          {cq_valid, cq_attr}, 9'h1A4);

      // R7 hub routing
      cycle(1, 6'h3F, 16'h7777, 0, 8'h5A, 1, 4'd2, 1);
      idle(1);
      chk(!hq_valid, "R7 hub not early", hq_valid, 0);
      idle(1);
      idle(1);
      chk(hq_valid && !cq_valid, "R7 hub pulse, cache quiet", {hq_valid, cq_valid}, 2'b10);
      idle(1);
      chk(!hq_valid, "R7 single cycle", hq_valid, 0);

      // R8/R9/R10 refusal and retry
      idle(0);
      cycle(1, 6'h01, 16'h0A01, 0, 8'h10, 0, 4'd0, 0);
      idle(0);
      chk(cq_valid, "R8 first offer direct", cq_valid, 1);
      for (int i = 1; i < 5; i++) begin
         cycle(1, 6'(i + 1), 16'h0A01 + 16'(i), 0, 8'h10 + 8'(i), 0, 4'd0, 0);
         idle(0);
      end
      chk(busy, "R10 full queue holds busy", busy, 1);
      chk(!cq_valid, "R9 no replay without ready", cq_valid, 0);
      acc_c = 0;
      idle(1);
      chk(!cq_valid, "R9 replay waits a cycle", cq_valid, 0);
      repeat (10) idle(1);
      chk(acc_c == 5, "R8 all five accepted", acc_c, 5);

      // constrained random
      for (int c = 0; c < 4000; c++) begin
         n = $urandom_range(0, 99);
         cycle(n < 40, 6'($urandom), 16'($urandom), $urandom_range(0, 1) == 1,
               8'($urandom), $urandom_range(0, 4) == 0, 4'($urandom_range(0, 6)),
               $urandom_range(0, 9) < 6);
      end
      repeat (60) idle(1);
      chk(exp_c.size() == 0, "R8 cache drain", exp_c.size(), 0);
      chk(exp_h.size() == 0, "R7 hub drain", exp_h.size(), 0);
      chk(!busy, "R6 idle at end", busy, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule